// File: doc/BRIEF.md
# Synthesizer Configuration Front End

This block holds the divider settings of a clock synthesizer: a 9-bit feedback divider value, a 2-bit post-divider select and a 3-bit test-node select. These values can be loaded in two ways. A parallel port takes the feedback and post-divider values on the rising edge of a parallel strobe. A three-wire serial port shifts a 14-bit word in on its own clock, and moves the word into the configuration registers on the falling edge of a serial strobe. If both loads arrive together, the parallel load wins. The serial load is accepted only while the parallel strobe is high.

All strobes and serial lines are asynchronous to the fast clock `clk`. Each one passes through a two-flop synchronizer, and edges are detected after that synchronizer. The parallel data lines must stay stable from before the parallel strobe rises until a few clock cycles after it. The block also turns the post-divider select into a ratio R of 1, 2, 4 or 8 and drives a divided clock from `clk`. Each high phase and each low phase of that clock lasts exactly R `clk` cycles, so the duty cycle is 50%. A new ratio is taken up only at an output edge.

Top module: `synth_cfg_front`

## Requirements
- R1: While reset is asserted and right after it is released, `cfg_m` is 0x1FF, `cfg_n` is 2'b11, `cfg_t` is 3'b111, `ratio` is 8 and `clk_div` is 0.
- R2: A rising edge on `par_load` copies `par_m` into `cfg_m` and `par_n` into `cfg_n`. `cfg_t` is left unchanged.
- R3: Each rising edge of `ser_clk` shifts `ser_data` into the bottom bit of a 14-bit shift register. A falling edge of `ser_load` while `par_load` is high loads the registers from that word as follows: bits 13..11 go to `cfg_t`, bits 10..9 go to `cfg_n` and bits 8..0 go to `cfg_m`. The word is therefore sent as T, then N, then M, most significant bit first in each field.
- R4: A falling edge of `ser_load` while `par_load` is low does not change `cfg_m`, `cfg_n` or `cfg_t`.
- R5: When a parallel rising edge and a serial falling edge are detected in the same cycle, the parallel values are taken and `cfg_t` keeps its value.
- R6: `ratio` is the decoded value of `cfg_n`: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R7: Every high phase and every low phase of `clk_div` lasts exactly R `clk` cycles, where R is the ratio in effect for that phase.
- R8: After `cfg_n` changes, every phase of `clk_div` has the length of either the old ratio or the new ratio. No shortened phase appears, and the new ratio applies from the next output edge onward.
- R9: If more than 14 bits are shifted in before a serial load, only the last 14 bits are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; also the source of the divided clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_m | input | 9 | Parallel feedback divider value |
| par_n | input | 2 | Parallel post-divider select |
| par_load | input | 1 | Parallel strobe; a rising edge loads the parallel values |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial strobe; a falling edge loads the shifted word |
| cfg_m | output | 9 | Current feedback divider value |
| cfg_n | output | 2 | Current post-divider select |
| cfg_t | output | 3 | Current test-node select |
| ratio | output | 4 | Decoded post-divide ratio: 1, 2, 4 or 8 |
| clk_div | output | 1 | Post-divided clock, 50% duty cycle |

## Verification
The bench drives a parallel rise and a serial fall at the same moment. A design with the wrong priority would load the serial word there and change `cfg_t`. It sends a serial load while the parallel strobe is low, which exposes a design that ignores the gating. It sends an overlong serial word, which catches a shift register that is too long or shifts in the wrong direction. A monitor measures every phase of `clk_div`, including across changes of the post-divider select in both directions. A divider that applies a new ratio in the middle of a phase would show a phase whose length matches neither the old ratio nor the new one.

// File: rtl/synth_cfg_front.sv
module synth_cfg_front #(
  parameter int M_W = 9,
  parameter int T_W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] par_m,
  input  logic [1:0]     par_n,
  input  logic           par_load,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] cfg_m,
  output logic [1:0]     cfg_n,
  output logic [T_W-1:0] cfg_t,
  output logic [3:0]     ratio,
  output logic           clk_div
);
  localparam int WORD_W = T_W + 2 + M_W;

  // sync bit map: 3 par_load, 2 ser_clk, 1 ser_data, 0 ser_load
  logic [3:0] sy1, sy2, sy3;
  logic [WORD_W-1:0] shreg;
  logic [3:0] half_q;
  logic [2:0] cnt;

  wire par_hi = sy2[3];
  wire p_rise = sy2[3] & ~sy3[3];
  wire c_rise = sy2[2] & ~sy3[2];
  wire l_fall = ~sy2[0] & sy3[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= {par_load, ser_clk, ser_data, ser_load};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      shreg <= '0;
    else if (c_rise) shreg <= {shreg[WORD_W-2:0], sy2[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_m <= '1;
      cfg_n <= '1;
      cfg_t <= '1;
    end else if (p_rise) begin
      cfg_m <= par_m;
      cfg_n <= par_n;
    end else if (l_fall && par_hi) begin
      {cfg_t, cfg_n, cfg_m} <= shreg;
    end

  assign ratio = 4'd1 << cfg_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      half_q  <= 4'd8;
      clk_div <= 1'b0;
    end else if (cnt == 3'(half_q - 4'd1)) begin
      cnt     <= '0;
      half_q  <= ratio;
      clk_div <= ~clk_div;
    end else begin
      cnt <= cnt + 3'd1;
    end
endmodule

// File: rtl/synth_cfg_front_chk.sv
module synth_cfg_front_chk #(
  parameter int M_W = 9,
  parameter int T_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           par_hi,
  input logic           p_rise,
  input logic           l_fall,
  input logic [M_W-1:0] par_m,
  input logic [1:0]     par_n,
  input logic [M_W-1:0] cfg_m,
  input logic [1:0]     cfg_n,
  input logic [T_W-1:0] cfg_t,
  input logic           clk_div
);
  logic       prev_div, seen;
  logic [3:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_div <= 1'b0;
      seen     <= 1'b0;
      run      <= 4'd1;
    end else if (clk_div != prev_div) begin
      prev_div <= clk_div;
      seen     <= 1'b1;
      run      <= 4'd1;
    end else if (run != 4'hf) begin
      run <= run + 4'd1;
    end

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_m == '1 && cfg_n == 2'b11 && cfg_t == '1 && !clk_div));

  // R4
  t_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_hi |=> $stable(cfg_t));

  // R3
  t_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_t != $past(cfg_t)) |-> $past(l_fall && par_hi));

  // R5
  par_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(p_rise) |-> (cfg_m == $past(par_m) && cfg_n == $past(par_n) && $stable(cfg_t)));

  // R7
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && clk_div != prev_div) |-> ($countones(run) == 1 && run <= 4'd8));

  wire unused_ok = ^cfg_n;
endmodule

bind synth_cfg_front synth_cfg_front_chk #(.M_W(M_W), .T_W(T_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_hi(par_hi), .p_rise(p_rise), .l_fall(l_fall),
  .par_m(par_m), .par_n(par_n), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t),
  .clk_div(clk_div)
);

// File: tb/sim_synth_cfg_front.sv
`timescale 1ns/1ps
module sim_synth_cfg_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic par_load = 1'b0, ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic [3:0] ratio;
  logic clk_div;

  int errs = 0, checks = 0;
  logic [8:0] em;
  logic [1:0] en;
  logic [2:0] et;
  bit done = 0;

  bit mon_en = 0, mon_seen = 0, mon_lvl = 0;
  int allow_a = 8, allow_b = 8, mon_cnt = 0;

  always #2.5 clk = ~clk;

  synth_cfg_front u0 (.*);

  function automatic logic [3:0] exp_ratio(input logic [1:0] n);
    return 4'd1 << n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req);
    chk(cfg_m == em, req, "cfg_m", cfg_m, em);
    chk(cfg_n == en, req, "cfg_n", cfg_n, en);
    chk(cfg_t == et, req, "cfg_t", cfg_t, et);
    chk(ratio == exp_ratio(en), "R6", "ratio", ratio, exp_ratio(en));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic par_load_do(input logic [8:0] m, input logic [1:0] n);
    par_load = 1'b0; cyc(6);
    par_m = m; par_n = n; cyc(2);
    par_load = 1'b1; cyc(8);
  endtask

  task automatic shift_bits(input logic [31:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      ser_data = w[i]; cyc(3);
      ser_clk = 1'b1; cyc(4);
      ser_clk = 1'b0; cyc(3);
    end
  endtask

  task automatic ser_strobe();
    ser_load = 1'b1; cyc(4);
    ser_load = 1'b0; cyc(6);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n || !mon_en) begin
      mon_seen = 0; mon_lvl = clk_div; mon_cnt = 0;
    end else if (clk_div != mon_lvl) begin
      if (mon_seen) begin
        checks++;
        if (mon_cnt != allow_a && mon_cnt != allow_b) begin
          errs++;
          $display("FAIL R7/R8 phase length: actual=%0d expected=%0d or %0d", mon_cnt, allow_a, allow_b);
        end
      end
      mon_seen = 1; mon_lvl = clk_div; mon_cnt = 1;
    end else begin
      mon_cnt++;
    end
  end

  initial begin
    cyc(150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int seed;
    logic [13:0] w;
    seed = $urandom(32'd20240611);
    cyc(5);
    @(negedge clk);
    em = 9'h1ff; en = 2'b11; et = 3'b111;
    chk_cfg("R1");
    chk(clk_div == 1'b0, "R1", "clk_div", clk_div, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_cfg("R1");
    chk(clk_div == 1'b0, "R1", "clk_div", clk_div, 0);

    par_load_do(9'h0a5, 2'b01);
    em = 9'h0a5; en = 2'b01;
    chk_cfg("R2");

    w = {3'b010, 2'b10, 9'h133};
    shift_bits(32'(w), 14); ser_strobe();
    {et, en, em} = w;
    chk_cfg("R3");

    for (int k = 0; k < 12; k++) begin
      if ($urandom % 2) begin
        w = 14'($urandom);
        shift_bits(32'(w), 14); ser_strobe();
        {et, en, em} = w;
        chk_cfg("R3");
      end else begin
        em = 9'($urandom); en = 2'($urandom);
        par_load_do(em, en);
        chk_cfg("R2");
      end
    end

    // R9: 17 bits, last 14 win
    w = {3'b101, 2'b00, 9'h05a};
    shift_bits({15'b0, 3'b110, w}, 17); ser_strobe();
    {et, en, em} = w;
    chk_cfg("R9");

    // R4: serial load while parallel strobe low
    par_load = 1'b0; cyc(6);
    shift_bits(32'({3'b000, 2'b11, 9'h000}), 14); ser_strobe();
    chk_cfg("R4");

    // R5: coincident parallel rise and serial fall
    shift_bits(32'({3'b011, 2'b01, 9'h111}), 14);
    ser_load = 1'b1; cyc(4);
    par_m = 9'h0c3; par_n = 2'b10; cyc(2);
    par_load = 1'b1; ser_load = 1'b0; cyc(8);
    em = 9'h0c3; en = 2'b10;
    chk_cfg("R5");

    // R7: steady phase lengths for each ratio
    for (int n = 0; n < 4; n++) begin
      par_load_do(9'h100, 2'(n));
      cyc(30);
      allow_a = 1 << n; allow_b = 1 << n;
      mon_en = 1; cyc(80); mon_en = 0;
      chk(ratio == exp_ratio(2'(n)), "R6", "ratio", ratio, exp_ratio(2'(n)));
    end

    // R8: ratio changes down and up
    allow_a = 8; allow_b = 8; mon_en = 1; cyc(40);
    allow_b = 1; par_load_do(9'h100, 2'b00); cyc(40);
    allow_a = 1; cyc(40);
    allow_b = 4; par_load_do(9'h100, 2'b10); cyc(40);
    allow_a = 4; cyc(40);
    allow_b = 2; par_load_do(9'h100, 2'b01); cyc(40);
    mon_en = 0;
    chk(ratio == 4'd2, "R8", "ratio", ratio, 2);

    report();
  end
endmodule